// File: doc/BRIEF.md
# Descriptor Poll-Demand Fetch Controller

This block holds the control registers for a descriptor-ring DMA engine and runs the descriptor-fetch sequence for both the receive and the transmit direction. Software writes a ring base address, a gap between descriptors, a bus priority bit and a run bit for each direction. When a direction is started, its sequencer reads the descriptor at the current pointer over a shared memory request/response port and looks at the ownership bit (bit 31 of the returned word).

If the hardware owns the descriptor, the sequencer raises a one-cycle start strobe with the descriptor address. The data mover outside this block then handles the buffer and answers with a done pulse, and the sequencer moves on to the next descriptor. If software still owns the descriptor, the sequencer latches a sticky "unavailable" flag and parks in a suspended state. It stays there until software writes the poll-demand register.

A fixed-priority arbiter, steered by one register bit, shares the memory port between the two sequencers. A self-clearing software reset returns the sequencers, run bits and status flags to idle and leaves the configuration intact.

Top module: `ring_fetch_ctrl`

Register map (byte offsets): 00h bus mode (bit 0 software reset, bit 1 priority with 1 = transmit wins, bits 6:2 gap in 32-bit words), 08h transmit poll, 10h receive poll, 18h receive base, 20h transmit base, 28h status (bit 0 receive unavailable, bit 1 transmit unavailable, bits 10:8 receive state, bits 14:12 transmit state), 30h run (bit 0 receive, bit 1 transmit). State codes are: 0 stopped, 1 fetch, 2 check, 3 run, 4 suspended. Response tag 0 means receive and tag 1 means transmit.

## Requirements
- R1: After reset every register reads 0, except the two poll registers, which read FFFFFFFFh. Both sequencers are stopped and mem_req is low.
- R2: A base register keeps bits 1:0 at zero on readback. A base write is ignored unless its sequencer is stopped. A write to the gap or priority fields is ignored unless both sequencers are stopped.
- R3: Setting a run bit while its sequencer is stopped loads the base address. The sequencer then issues one descriptor read at that address, tagged with its direction.
- R4: A read response with bit 31 set produces a one-cycle start strobe carrying the descriptor address, and the state becomes run (3).
- R5: A read response with bit 31 clear sets the direction's unavailable flag and the state becomes suspended (4). No start strobe is produced.
- R6: A poll write in the suspended state re-reads the same descriptor. A poll write in any other state has no effect.
- R7: After a done pulse, the next descriptor read is at the previous address + descriptor size (16 bytes) + 4 × gap.
- R8: When both sequencers request in the same cycle, the transmit side is served first if the priority bit is 1, and the receive side is served first otherwise.
- R9: The unavailable flags are sticky. Writing 1 to a flag clears it, and writing 0 leaves it unchanged.
- R10: Writing 1 to bit 0 of the bus-mode register holds that bit at 1 for 4 cycles, after which it clears itself. It stops both sequencers and clears the run bits and the status flags. The base, gap and priority settings are kept.
- R11: Clearing a run bit returns a running or suspended sequencer to stopped (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_tag | output | 1 | Requesting direction (1 transmit) |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rtag | input | 1 | Direction of the response |
| mem_rdata | input | 32 | Descriptor first word |
| rx_start | output | 1 | Receive descriptor owned, begin move |
| rx_start_addr | output | 32 | Receive descriptor address |
| rx_done | input | 1 | Receive descriptor finished |
| tx_start | output | 1 | Transmit descriptor owned, begin send |
| tx_start_addr | output | 32 | Transmit descriptor address |
| tx_done | input | 1 | Transmit descriptor finished |

## Verification
Both sequencers can raise a descriptor read in the same cycle, and the arbiter has to pick one of them according to the priority bit. The bench holds the grant low and sets both run bits with a single write, so the two requests pile up together. It then checks the tag and address offered on the port, first with the priority bit set to transmit and again with it set to receive. A scoreboard queue of expected (tag, address) pairs judges the order in which the grants go out once the grant is released, and a second queue judges the order of the start strobes.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

   localparam int REG_W = 32;

   typedef enum logic [2:0] {
      ST_STOP  = 3'd0,
      ST_FETCH = 3'd1,
      ST_CHECK = 3'd2,
      ST_RUN   = 3'd3,
      ST_SUSP  = 3'd4
   } rfc_state_e;

   localparam logic [7:0] OFS_BUS    = 8'h00;
   localparam logic [7:0] OFS_TXPOLL = 8'h08;
   localparam logic [7:0] OFS_RXPOLL = 8'h10;
   localparam logic [7:0] OFS_RXBASE = 8'h18;
   localparam logic [7:0] OFS_TXBASE = 8'h20;
   localparam logic [7:0] OFS_STAT   = 8'h28;
   localparam logic [7:0] OFS_RUN    = 8'h30;

   localparam int BM_SWR     = 0;
   localparam int BM_PRIO    = 1;
   localparam int BM_GAP_LO  = 2;
   localparam int STAT_RXST  = 8;
   localparam int STAT_TXST  = 12;

endpackage

// File: rtl/rfc_engine.sv
module rfc_engine
   import rfc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DESC_BYTES = 16,
   parameter int SKIP_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              run_i,
   input  logic              poll_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [SKIP_W-1:0] skip_i,
   output logic              req_o,
   output logic [ADDR_W-1:0] addr_o,
   input  logic              gnt_i,
   input  logic              rsp_hit_i,
   input  logic              rsp_own_i,
   output logic              start_o,
   output logic [ADDR_W-1:0] start_addr_o,
   input  logic              done_i,
   output logic              unavail_o,
   output rfc_state_e        state_o
);

   rfc_state_e        state_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] step;
   logic              live;

   assign step = ADDR_W'(DESC_BYTES) + (ADDR_W'(skip_i) << 2);
   assign live = run_i && !soft_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_STOP;
         cur_q   <= '0;
      end else if (soft_rst) begin
         state_q <= ST_STOP;
      end else begin
         unique case (state_q)
            ST_STOP: if (run_i) begin
               cur_q   <= base_i;
               state_q <= ST_FETCH;
            end
            ST_FETCH: begin
               if (!run_i)     state_q <= ST_STOP;
               else if (gnt_i) state_q <= ST_CHECK;
            end
            ST_CHECK: if (rsp_hit_i) begin
               if (!run_i)         state_q <= ST_STOP;
               else if (rsp_own_i) state_q <= ST_RUN;
               else                state_q <= ST_SUSP;
            end
            ST_RUN: begin
               if (!run_i) state_q <= ST_STOP;
               else if (done_i) begin
                  cur_q   <= cur_q + step;
                  state_q <= ST_FETCH;
               end
            end
            ST_SUSP: begin
               if (!run_i)      state_q <= ST_STOP;
               else if (poll_i) state_q <= ST_FETCH;
            end
            default: state_q <= ST_STOP;
         endcase
      end
   end

   assign req_o        = (state_q == ST_FETCH) && live;
   assign addr_o       = cur_q;
   assign start_o      = (state_q == ST_CHECK) && rsp_hit_i && live && rsp_own_i;
   assign unavail_o    = (state_q == ST_CHECK) && rsp_hit_i && live && !rsp_own_i;
   assign start_addr_o = cur_q;
   assign state_o      = state_q;

   a_r3_req_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !gnt_i) |=> $stable(addr_o));

   a_r4_start_enters_run: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> (state_q == ST_RUN));

   a_r5_unavail_suspends: assert property (@(posedge clk) disable iff (!rst_n)
      unavail_o |=> (state_q == ST_SUSP));

   a_r11_stop_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && (state_q == ST_RUN || state_q == ST_SUSP)) |=> (state_q == ST_STOP));

   a_r6_poll_needs_susp: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && run_i && !done_i && !soft_rst) |=> (state_q == ST_RUN));

endmodule

// File: rtl/rfc_arbiter.sv
module rfc_arbiter #(
   parameter int ADDR_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             req_i,
   input  logic [1:0][ADDR_W-1:0] addr_i,
   input  logic                   prio_tx_i,
   input  logic                   mem_gnt,
   output logic                   mem_req,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic                   mem_tag,
   output logic [1:0]             gnt_o
);

   logic pick_tx;

   assign pick_tx  = req_i[1] && (!req_i[0] || prio_tx_i);
   assign mem_req  = |req_i;
   assign mem_tag  = pick_tx;
   assign mem_addr = pick_tx ? addr_i[1] : addr_i[0];
   assign gnt_o[1] = mem_gnt && pick_tx;
   assign gnt_o[0] = mem_gnt && req_i[0] && !pick_tx;

   a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));

   a_r8_priority_order: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[0] && req_i[1]) |-> (mem_tag == prio_tx_i));

   a_r8_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_o != 2'b00 |-> (mem_req && mem_gnt));

endmodule

// File: rtl/ring_fetch_ctrl.sv
module ring_fetch_ctrl
   import rfc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int OWN_BIT    = 31,
   parameter int DESC_BYTES = 16,
   parameter int SKIP_W     = 5,
   parameter int RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [7:0]        reg_waddr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic [7:0]        reg_raddr,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_tag,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic              mem_rtag,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rx_start,
   output logic [ADDR_W-1:0] rx_start_addr,
   input  logic              rx_done,
   output logic              tx_start,
   output logic [ADDR_W-1:0] tx_start_addr,
   input  logic              tx_done
);

   localparam int NENG  = 2;
   localparam int CNT_W = $clog2(RST_CYCLES + 1);
   localparam int GAP_HI = BM_GAP_LO + SKIP_W - 1;

   if (DESC_BYTES < 4 || (DESC_BYTES % 4) != 0) begin : g_bad_desc
      $error("DESC_BYTES must be a positive multiple of 4");
   end
   if (ADDR_W < 8 || ADDR_W > REG_W) begin : g_bad_addr
      $error("ADDR_W must lie between 8 and the register width");
   end
   if (OWN_BIT >= DATA_W) begin : g_bad_own
      $error("OWN_BIT must index a bit of the response word");
   end
   if (GAP_HI >= 8 || RST_CYCLES < 1) begin : g_bad_cfg
      $error("gap field must fit below bit 8 and reset must last a cycle");
   end

   logic [NENG-1:0]             run_q, unav_q, eng_req, eng_gnt, eng_start;
   logic [NENG-1:0]             eng_unav, eng_poll, eng_done, rsp_hit;
   logic [NENG-1:0][ADDR_W-1:0] eng_addr, start_addr, base_q;
   rfc_state_e                  eng_state [NENG];
   logic [SKIP_W-1:0]           gap_q;
   logic                        prio_tx_q, swr_q;
   logic [CNT_W-1:0]            swr_cnt;
   logic                        wr_bus, wr_run, wr_stat, both_stopped;
   logic                        unused_rdata;

   assign wr_bus       = reg_we && (reg_waddr == OFS_BUS);
   assign wr_run       = reg_we && (reg_waddr == OFS_RUN);
   assign wr_stat      = reg_we && (reg_waddr == OFS_STAT);
   assign both_stopped = (eng_state[0] == ST_STOP) && (eng_state[1] == ST_STOP);
   assign eng_done     = {tx_done, rx_done};
   assign unused_rdata = ^mem_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q     <= '0;
         prio_tx_q <= 1'b0;
         swr_q     <= 1'b0;
         swr_cnt   <= '0;
         run_q     <= '0;
      end else begin
         if (wr_bus && both_stopped && !swr_q) begin
            gap_q     <= reg_wdata[GAP_HI:BM_GAP_LO];
            prio_tx_q <= reg_wdata[BM_PRIO];
         end
         if (swr_q) begin
            if (swr_cnt == '0) swr_q <= 1'b0;
            else               swr_cnt <= swr_cnt - 1'b1;
         end else if (wr_bus && reg_wdata[BM_SWR]) begin
            swr_q   <= 1'b1;
            swr_cnt <= CNT_W'(RST_CYCLES - 1);
         end
         if (swr_q)       run_q <= '0;
         else if (wr_run) run_q <= reg_wdata[NENG-1:0];
      end
   end

   for (genvar g = 0; g < NENG; g++) begin : g_eng
      localparam logic [7:0] P_OFS = (g == 0) ? OFS_RXPOLL : OFS_TXPOLL;
      localparam logic [7:0] B_OFS = (g == 0) ? OFS_RXBASE : OFS_TXBASE;
      logic wr_base, clr;

      assign wr_base     = reg_we && (reg_waddr == B_OFS) && (eng_state[g] == ST_STOP);
      assign eng_poll[g] = reg_we && (reg_waddr == P_OFS);
      assign rsp_hit[g]  = mem_rvalid && (mem_rtag == 1'(g));
      assign clr         = wr_stat && reg_wdata[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[g] <= '0;
            unav_q[g] <= 1'b0;
         end else begin
            if (wr_base) base_q[g] <= {reg_wdata[ADDR_W-1:2], 2'b00};
            if (swr_q) unav_q[g] <= 1'b0;
            else       unav_q[g] <= (unav_q[g] && !clr) || eng_unav[g];
         end
      end

      rfc_engine #(
         .ADDR_W    (ADDR_W),
         .DESC_BYTES(DESC_BYTES),
         .SKIP_W    (SKIP_W)
      ) u_engine (
         .clk         (clk),
         .rst_n       (rst_n),
         .soft_rst    (swr_q),
         .run_i       (run_q[g]),
         .poll_i      (eng_poll[g]),
         .base_i      (base_q[g]),
         .skip_i      (gap_q),
         .req_o       (eng_req[g]),
         .addr_o      (eng_addr[g]),
         .gnt_i       (eng_gnt[g]),
         .rsp_hit_i   (rsp_hit[g]),
         .rsp_own_i   (mem_rdata[OWN_BIT]),
         .start_o     (eng_start[g]),
         .start_addr_o(start_addr[g]),
         .done_i      (eng_done[g]),
         .unavail_o   (eng_unav[g]),
         .state_o     (eng_state[g])
      );

      a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (unav_q[g] && !clr && !swr_q) |=> unav_q[g]);

      a_r2_base_guard: assert property (@(posedge clk) disable iff (!rst_n)
         (eng_state[g] != ST_STOP) |=> $stable(base_q[g]));
   end

   rfc_arbiter #(.ADDR_W(ADDR_W)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (eng_req),
      .addr_i   (eng_addr),
      .prio_tx_i(prio_tx_q),
      .mem_gnt  (mem_gnt),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .mem_tag  (mem_tag),
      .gnt_o    (eng_gnt)
   );

   assign rx_start      = eng_start[0];
   assign tx_start      = eng_start[1];
   assign rx_start_addr = start_addr[0];
   assign tx_start_addr = start_addr[1];

   always_comb begin
      reg_rdata = '0;
      unique case (reg_raddr)
         OFS_BUS: begin
            reg_rdata[BM_SWR]            = swr_q;
            reg_rdata[BM_PRIO]           = prio_tx_q;
            reg_rdata[GAP_HI:BM_GAP_LO]  = gap_q;
         end
         OFS_TXPOLL, OFS_RXPOLL: reg_rdata = '1;
         OFS_RXBASE: reg_rdata = REG_W'(base_q[0]);
         OFS_TXBASE: reg_rdata = REG_W'(base_q[1]);
         OFS_STAT: begin
            reg_rdata[NENG-1:0]           = unav_q;
            reg_rdata[STAT_RXST +: 3]     = eng_state[0];
            reg_rdata[STAT_TXST +: 3]     = eng_state[1];
         end
         OFS_RUN: reg_rdata[NENG-1:0] = run_q;
         default: reg_rdata = '0;
      endcase
   end

   a_r10_reset_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
      swr_q |=> (run_q == '0));

   a_r10_reset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (swr_q && swr_cnt == '0) |=> !swr_q);

   a_r2_cfg_guard: assert property (@(posedge clk) disable iff (!rst_n)
      !both_stopped |=> ($stable(gap_q) && $stable(prio_tx_q)));

endmodule

// File: tb/ring_fetch_ctrl_tb.sv
module ring_fetch_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_waddr = '0, reg_raddr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        mem_req, mem_tag;
   logic [31:0] mem_addr;
   logic        mem_gnt = 1'b1, mem_rvalid = 1'b0, mem_rtag = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        rx_start, tx_start, rx_done = 1'b0, tx_done = 1'b0;
   logic [31:0] rx_start_addr, tx_start_addr;

   always #4 clk = ~clk;

   ring_fetch_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_tag(mem_tag),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rtag(mem_rtag),
      .mem_rdata(mem_rdata), .rx_start(rx_start), .rx_start_addr(rx_start_addr),
      .rx_done(rx_done), .tx_start(tx_start), .tx_start_addr(tx_start_addr),
      .tx_done(tx_done)
   );

   typedef struct {
      bit          tag;
      logic [31:0] addr;
      string       rq;
   } item_t;

   item_t fetch_q[$];
   item_t start_q[$];
   bit    own_tbl[int];
   int    n_chk = 0;
   int    n_err = 0;
   bit    pend = 1'b0;
   bit    ptag = 1'b0;
   logic [31:0] paddr = '0;

   task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_raddr = a;
      #3 d = reg_rdata;
   endtask

   task automatic finish_desc(bit t);
      @(negedge clk);
      if (t) tx_done = 1'b1; else rx_done = 1'b1;
      @(posedge clk); #1;
      tx_done = 1'b0; rx_done = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_fetch(bit t, logic [31:0] a, string rq);
      item_t it;
      it.tag = t; it.addr = a; it.rq = rq;
      fetch_q.push_back(it);
   endtask

   task automatic expect_start(bit t, logic [31:0] a, string rq);
      item_t it;
      it.tag = t; it.addr = a; it.rq = rq;
      start_q.push_back(it);
   endtask

   // memory responder and fetch scoreboard
   initial begin
      forever begin
         @(negedge clk);
         mem_rvalid = pend;
         mem_rtag   = ptag;
         mem_rdata  = (pend && own_tbl.exists(int'(paddr)) && own_tbl[int'(paddr)])
                      ? 32'h8000_0000 : 32'h0000_1234;
         pend = 1'b0;
         #3;
         if (mem_req && mem_gnt) begin
            n_chk++;
            if (fetch_q.size() == 0) begin
               n_err++;
               $display("FAIL R3/R6 unexpected fetch actual tag=%0d addr=%h expected none",
                        mem_tag, mem_addr);
            end else begin
               item_t e;
               e = fetch_q.pop_front();
               if (e.tag !== mem_tag || e.addr !== mem_addr) begin
                  n_err++;
                  $display("FAIL %s fetch actual tag=%0d addr=%h expected tag=%0d addr=%h",
                           e.rq, mem_tag, mem_addr, e.tag, e.addr);
               end
            end
            pend = 1'b1; ptag = mem_tag; paddr = mem_addr;
         end
      end
   end

   // start-strobe scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (rx_start || tx_start) begin
            bit          t;
            logic [31:0] a;
            t = tx_start;
            a = tx_start ? tx_start_addr : rx_start_addr;
            n_chk++;
            if (start_q.size() == 0) begin
               n_err++;
               $display("FAIL R4/R5 unexpected start actual tag=%0d addr=%h expected none", t, a);
            end else begin
               item_t e;
               e = start_q.pop_front();
               if (e.tag !== t || e.addr !== a) begin
                  n_err++;
                  $display("FAIL %s start actual tag=%0d addr=%h expected tag=%0d addr=%h",
                           e.rq, t, a, e.tag, e.addr);
               end
            end
         end
      end
   end

   initial begin
      #800000;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int          ones;
      idle(3);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, d); chk("R1 bus mode", d, 32'h0);
      rd(8'h08, d); chk("R1 tx poll", d, 32'hFFFF_FFFF);
      rd(8'h10, d); chk("R1 rx poll", d, 32'hFFFF_FFFF);
      rd(8'h28, d); chk("R1 status", d, 32'h0);
      chk("R1 mem_req idle", 32'(mem_req), 32'h0);

      // R2 base alignment, configuration while stopped
      wr(8'h18, 32'h0000_1003);
      rd(8'h18, d); chk("R2 rx base aligned", d, 32'h0000_1000);
      wr(8'h20, 32'h0000_2000);
      wr(8'h00, 32'h0000_0008);
      rd(8'h00, d); chk("R2 gap written while stopped", d, 32'h0000_0008);

      // R3/R4 start receive, owned descriptor
      own_tbl[32'h1000] = 1'b1;
      expect_fetch(1'b0, 32'h1000, "R3");
      expect_start(1'b0, 32'h1000, "R4");
      wr(8'h30, 32'h1);
      idle(6);
      rd(8'h28, d); chk("R4 rx state run", (d >> 8) & 32'h7, 32'h3);

      // R2 base write ignored while running; R6 poll ignored while running
      wr(8'h18, 32'h0000_5000);
      rd(8'h18, d); chk("R2 base ignored when running", d, 32'h0000_1000);
      wr(8'h10, 32'h0);
      idle(3);
      rd(8'h28, d); chk("R6 poll outside suspend", (d >> 8) & 32'h7, 32'h3);

      // R7 next address with gap 2; R5 not owned
      expect_fetch(1'b0, 32'h1018, "R7");
      finish_desc(1'b0);
      idle(6);
      rd(8'h28, d); chk("R5 rx suspended flagged", d & 32'h703, 32'h401);

      // R9 write 0 keeps flag
      wr(8'h28, 32'h0);
      rd(8'h28, d); chk("R9 write zero keeps flag", d & 32'h3, 32'h1);

      // R6 poll in suspend re-reads the same descriptor
      own_tbl[32'h1018] = 1'b1;
      expect_fetch(1'b0, 32'h1018, "R6");
      expect_start(1'b0, 32'h1018, "R6");
      wr(8'h10, 32'h0);
      idle(6);
      rd(8'h28, d); chk("R6 run after poll, flag sticky", d & 32'h703, 32'h301);
      wr(8'h28, 32'h1);
      rd(8'h28, d); chk("R9 write one clears", d & 32'h3, 32'h0);

      // R11 stop
      wr(8'h30, 32'h0);
      idle(3);
      rd(8'h28, d); chk("R11 stopped", d, 32'h0);

      // R8 transmit priority with both requesting at once
      wr(8'h00, 32'h0000_000A);
      rd(8'h00, d); chk("R2 prio written while stopped", d, 32'h0000_000A);
      own_tbl[32'h2000] = 1'b1;
      @(negedge clk) mem_gnt = 1'b0;
      expect_fetch(1'b1, 32'h2000, "R8 tx first");
      expect_fetch(1'b0, 32'h1000, "R8 rx second");
      expect_start(1'b1, 32'h2000, "R8 tx first");
      expect_start(1'b0, 32'h1000, "R8 rx second");
      wr(8'h30, 32'h3);
      idle(2); #3;
      chk("R8 tx wins tag", 32'(mem_tag), 32'h1);
      chk("R8 tx wins addr", mem_addr, 32'h2000);
      @(negedge clk) mem_gnt = 1'b1;
      idle(8);

      // R2 gap write ignored while running
      wr(8'h00, 32'h0000_001C);
      rd(8'h00, d); chk("R2 gap ignored when running", d, 32'h0000_000A);

      // R8 receive priority
      wr(8'h30, 32'h0);
      idle(3);
      wr(8'h00, 32'h0000_0008);
      @(negedge clk) mem_gnt = 1'b0;
      expect_fetch(1'b0, 32'h1000, "R8 rx first");
      expect_fetch(1'b1, 32'h2000, "R8 tx second");
      expect_start(1'b0, 32'h1000, "R8 rx first");
      expect_start(1'b1, 32'h2000, "R8 tx second");
      wr(8'h30, 32'h3);
      idle(2); #3;
      chk("R8 rx wins tag", 32'(mem_tag), 32'h0);
      chk("R8 rx wins addr", mem_addr, 32'h1000);
      @(negedge clk) mem_gnt = 1'b1;
      idle(8);
      rd(8'h28, d); chk("R8 both running", d & 32'h7700, 32'h3300);

      // R10 software reset while both run
      wr(8'h00, 32'h0000_0001);
      ones = 0;
      for (int i = 0; i < 10; i++) begin
         rd(8'h00, d);
         if (d[0]) ones++;
      end
      chk("R10 reset bit duration", 32'(ones), 32'd4);
      rd(8'h00, d); chk("R10 config kept", d, 32'h0000_0008);
      rd(8'h30, d); chk("R10 run cleared", d, 32'h0);
      rd(8'h28, d); chk("R10 sequencers stopped", d, 32'h0);
      rd(8'h18, d); chk("R10 base kept", d, 32'h0000_1000);
      chk("R10 no request", 32'(mem_req), 32'h0);

      idle(4);
      chk("R3 fetch queue drained", 32'(fetch_q.size()), 32'h0);
      chk("R4 start queue drained", 32'(start_q.size()), 32'h0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule